// File: doc/BRIEF.md
# Maskable Edge/Level Interrupt Redirection Entry

This block holds the state for one external interrupt line on its way to a processor. Software configures two bits, a mask and a trigger mode (edge or level). The block synchronises the raw pin, decides which transitions count, and issues a one-cycle delivery request toward the processor side. The processor side answers with an accept pulse and, for level-triggered sources, later with an end-of-interrupt pulse.

The masking rule is strict. Anything the pin does while the mask is set is dropped, not queued. This holds for edges and for level rises and falls, so a level-triggered source that asserts while masked is lost until it produces a fresh rising transition while unmasked. A delivery-busy flag covers the time from request to accept. A remote-pending flag covers the time from accept to end-of-interrupt in level mode. Both flags can be read back through the register port.

Top module: `irq_redir_entry`

## Requirements
- R1: After reset, `dlv_req` is 0 and `reg_rdata` is 4'b0001. The bit positions are mask = bit 0, trigger mode = bit 1, remote-pending = bit 2, delivery-busy = bit 3.
- R2: A cycle with `reg_we` high loads `reg_wdata[0]` as the mask (1 = masked, 0 = enabled) and `reg_wdata[1]` as the trigger mode (0 = edge, 1 = level). Both values show in `reg_rdata` from the next cycle.
- R3: In edge mode with the pin enabled, a rising pin makes `dlv_req` high for exactly one cycle, starting at the third rising clock edge after the pin changes.
- R4: In edge mode, a rising edge that occurs while masked never produces a request, either during the masked period or after a later unmask.
- R5: Delivery-busy is set together with `dlv_req` and cleared by `dlv_accept`. An accept while delivery-busy is clear changes nothing.
- R6: In edge mode, further rising edges that arrive while delivery-busy is set are merged into the outstanding request, and no extra request follows the accept.
- R7: In edge mode, an accept never sets remote-pending.
- R8: In level mode with the pin enabled, a rising pin raises `dlv_req` at the fourth rising clock edge after the change. An accept sets remote-pending, and no request is issued while remote-pending is set.
- R9: `dlv_eoi` clears remote-pending. If the level is still active, a new request follows at the next rising edge after the one that samples the end-of-interrupt pulse. If the level has fallen while enabled, no request follows.
- R10: In level mode, a rise that happens while masked is ignored, so a later unmask with the pin already high produces no request.
- R11: In level mode, a fall that happens while masked is ignored. After unmask, the level is still treated as active and is delivered.
- R12: Setting the mask after an accept leaves remote-pending set, and a later `dlv_eoi` still clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 1 | Asynchronous interrupt line |
| reg_we | input | 1 | Configuration write strobe |
| reg_wdata | input | 2 | {trigger mode, mask} |
| reg_rdata | output | 4 | {delivery-busy, remote-pending, trigger mode, mask} |
| dlv_req | output | 1 | One-cycle delivery request |
| dlv_accept | input | 1 | Destination has taken the request |
| dlv_eoi | input | 1 | End of interrupt for a level-mode delivery |

## Verification
A stuck delivery-busy flag shows within one cycle of an accept as bit 3 of `reg_rdata` and as a missing next request. A stale level-active state shows as a request that appears after an unmask or an end-of-interrupt when none is expected, one or two edges later. A remote-pending flag that sets in edge mode, or fails to clear, shows in `reg_rdata` in the cycle after the accept or end-of-interrupt pulse. Timing errors in the synchroniser or edge detector move the request away from its exact edge, which the directed checks observe by sampling at that edge.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int CFG_W  = 2;
  localparam int STAT_W = 4;
  localparam int F_MASK = 0;
  localparam int F_TRIG = 1;
  localparam int F_RIRR = 2;
  localparam int F_BUSY = 3;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  typedef struct packed {
    trig_e trig;
    logic  mask;
  } cfg_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= pin_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic mask_i,
  output logic rise_o,
  output logic act_o
);
  logic prev_q;
  logic act_q;
  logic rise;
  logic fall;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  // prev always tracks, so transitions seen while masked are consumed
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  // level state only moves on transitions observed while enabled
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
    end else if (!mask_i) begin
      if (rise)      act_q <= 1'b1;
      else if (fall) act_q <= 1'b0;
    end
  end

  assign rise_o = rise & ~mask_i;
  assign act_o  = act_q;
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_redir_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  trig_e trig_i,
  input  logic  mask_i,
  input  logic  edge_ev_i,
  input  logic  lvl_act_i,
  input  logic  accept_i,
  input  logic  eoi_i,
  output logic  req_o,
  output logic  busy_o,
  output logic  rirr_o
);
  logic req_q;
  logic busy_q;
  logic rirr_q;
  logic fire_edge;
  logic fire_lvl;
  logic fire;

  assign fire_edge = (trig_i == TRIG_EDGE) & edge_ev_i & ~busy_q;
  assign fire_lvl  = (trig_i == TRIG_LEVEL) & lvl_act_i & ~mask_i
                     & ~busy_q & ~rirr_q;
  assign fire      = fire_edge | fire_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      req_q <= fire;
      if (fire)          busy_q <= 1'b1;
      else if (accept_i) busy_q <= 1'b0;
      if (busy_q && accept_i && trig_i == TRIG_LEVEL) rirr_q <= 1'b1;
      else if (eoi_i)                                 rirr_q <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign busy_o = busy_q;
  assign rirr_o = rirr_q;
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_pin,
  input  logic              reg_we,
  input  logic [CFG_W-1:0]  reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              dlv_req,
  input  logic              dlv_accept,
  input  logic              dlv_eoi
);
  cfg_t cfg_q;
  logic pin_lvl;
  logic edge_ev;
  logic lvl_act;
  logic busy_q;
  logic rirr_q;
  logic cfg_mask;
  logic cfg_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.mask <= 1'b1;
      cfg_q.trig <= TRIG_EDGE;
    end else if (reg_we) begin
      cfg_q <= cfg_t'(reg_wdata);
    end
  end

  assign cfg_mask  = cfg_q.mask;
  assign cfg_level = (cfg_q.trig == TRIG_LEVEL);

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_i (irq_pin),
    .lvl_o (pin_lvl)
  );

  irq_detect u_det (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (pin_lvl),
    .mask_i (cfg_mask),
    .rise_o (edge_ev),
    .act_o  (lvl_act)
  );

  irq_flags u_flags (
    .clk       (clk),
    .rst       (rst),
    .trig_i    (cfg_q.trig),
    .mask_i    (cfg_mask),
    .edge_ev_i (edge_ev),
    .lvl_act_i (lvl_act),
    .accept_i  (dlv_accept),
    .eoi_i     (dlv_eoi),
    .req_o     (dlv_req),
    .busy_o    (busy_q),
    .rirr_o    (rirr_q)
  );

  always_comb begin
    reg_rdata         = '0;
    reg_rdata[F_MASK] = cfg_mask;
    reg_rdata[F_TRIG] = cfg_level;
    reg_rdata[F_RIRR] = rirr_q;
    reg_rdata[F_BUSY] = busy_q;
  end
endmodule

// File: rtl/irq_redir_entry_chk.sv
module irq_redir_entry_chk (
  input logic clk,
  input logic rst,
  input logic dlv_req,
  input logic dlv_accept,
  input logic dlv_eoi,
  input logic mask,
  input logic level,
  input logic busy,
  input logic rirr
);
  // R3: request lasts one cycle
  p_req_single_r3: assert property (@(posedge clk) disable iff (rst)
    dlv_req |=> !dlv_req);
  // R4: requests only come from an enabled pin
  p_req_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
    dlv_req |-> !$past(mask));
  // R5: busy goes up only with a request
  p_busy_with_req_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> dlv_req);
  // R5: accept clears busy
  p_accept_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && dlv_accept && !dlv_req) |=> !busy);
  // R7: remote-pending only rises in level mode
  p_rirr_level_only_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rirr) |-> $past(level));
  // R8: no level request while remote-pending
  p_rirr_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (rirr && level) |=> !dlv_req);
  // R9: end-of-interrupt clears remote-pending
  p_eoi_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (rirr && dlv_eoi && !(busy && dlv_accept)) |=> !rirr);
endmodule

bind irq_redir_entry irq_redir_entry_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .dlv_req    (dlv_req),
  .dlv_accept (dlv_accept),
  .dlv_eoi    (dlv_eoi),
  .mask       (cfg_mask),
  .level      (cfg_level),
  .busy       (busy_q),
  .rirr       (rirr_q)
);

// File: tb/irq_redir_entry_test.sv
module irq_redir_entry_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       irq_pin = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic       dlv_req;
  logic       dlv_accept = 1'b0;
  logic       dlv_eoi = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_redir_entry uut (
    .clk        (clk),
    .rst        (rst),
    .irq_pin    (irq_pin),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .dlv_req    (dlv_req),
    .dlv_accept (dlv_accept),
    .dlv_eoi    (dlv_eoi)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic m, input logic t);
    reg_we = 1'b1; reg_wdata = {t, m};
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic pulse_accept();
    dlv_accept = 1'b1; step(1); dlv_accept = 1'b0;
  endtask

  task automatic pulse_eoi();
    dlv_eoi = 1'b1; step(1); dlv_eoi = 1'b0;
  endtask

  task automatic count_req(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (dlv_req) cnt++;
    end
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata, 4'b0001);
    chk("R1 req", dlv_req, 0);
  endtask

  task automatic t_regs();
    wr(1'b0, 1'b1);
    chk("R2 level enabled", reg_rdata, 4'b0010);
    wr(1'b1, 1'b0);
    chk("R2 edge masked", reg_rdata, 4'b0001);
    wr(1'b0, 1'b0);
    chk("R2 edge enabled", reg_rdata, 4'b0000);
  endtask

  task automatic t_edge();
    irq_pin = 1'b1;
    step(2);
    chk("R3 no early req", dlv_req, 0);
    step(1);
    chk("R3 req on third edge", dlv_req, 1);
    chk("R5 busy with req", reg_rdata[3], 1);
    step(1);
    chk("R3 req one cycle", dlv_req, 0);
    pulse_accept();
    chk("R5 R7 after accept", reg_rdata, 4'b0000);
    irq_pin = 1'b0;
    step(4);
  endtask

  task automatic t_edge_merge();
    int cnt;
    irq_pin = 1'b1;
    step(3);
    chk("R6 first req", dlv_req, 1);
    irq_pin = 1'b0; step(2);
    irq_pin = 1'b1;
    count_req(5, cnt);
    chk("R6 merged while busy", cnt, 0);
    pulse_accept();
    count_req(6, cnt);
    chk("R6 none after accept", cnt, 0);
    irq_pin = 1'b0; step(4);
  endtask

  task automatic t_edge_masked();
    int cnt;
    wr(1'b1, 1'b0);
    irq_pin = 1'b1;
    count_req(6, cnt);
    chk("R4 masked edge", cnt, 0);
    wr(1'b0, 1'b0);
    count_req(6, cnt);
    chk("R4 not pending after unmask", cnt, 0);
    pulse_accept();
    chk("R5 idle accept ignored", reg_rdata, 4'b0000);
    irq_pin = 1'b0; step(4);
  endtask

  task automatic t_level();
    int cnt;
    wr(1'b0, 1'b1);
    irq_pin = 1'b1;
    step(3);
    chk("R8 no req at third edge", dlv_req, 0);
    step(1);
    chk("R8 req at fourth edge", dlv_req, 1);
    step(1);
    chk("R8 req one cycle", dlv_req, 0);
    pulse_accept();
    chk("R8 remote pending set", reg_rdata, 4'b0110);
    count_req(8, cnt);
    chk("R8 blocked while pending", cnt, 0);
    pulse_eoi();
    chk("R9 eoi clears", reg_rdata[2], 0);
    step(1);
    chk("R9 redeliver active level", dlv_req, 1);
    pulse_accept();
    irq_pin = 1'b0; step(4);
    pulse_eoi();
    count_req(8, cnt);
    chk("R9 no req after fall", cnt, 0);
  endtask

  task automatic t_level_masked_rise();
    int cnt;
    wr(1'b1, 1'b1);
    irq_pin = 1'b1; step(6);
    wr(1'b0, 1'b1);
    count_req(8, cnt);
    chk("R10 masked rise lost", cnt, 0);
    irq_pin = 1'b0; step(4);
    irq_pin = 1'b1; step(4);
    chk("R10 fresh rise delivers", dlv_req, 1);
    step(1);
    pulse_accept();
    chk("R10 accepted", reg_rdata, 4'b0110);
  endtask

  task automatic t_mask_after_accept();
    int cnt;
    wr(1'b1, 1'b1);
    chk("R12 pending kept after mask", reg_rdata, 4'b0111);
    irq_pin = 1'b0; step(6);
    pulse_eoi();
    chk("R12 eoi clears while masked", reg_rdata, 4'b0011);
    count_req(6, cnt);
    chk("R11 masked no req", cnt, 0);
    wr(1'b0, 1'b1);
    step(1);
    chk("R11 masked fall ignored", dlv_req, 1);
    step(1);
    pulse_accept();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_regs();
    t_edge();
    t_edge_merge();
    t_edge_masked();
    t_level();
    t_level_masked_rise();
    t_mask_after_accept();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule